// File: doc/BRIEF.md
# Saturating Float/Integer Converter

This block converts a 32-bit operand in either direction between signed two's-complement integers and single-precision floating-point values. A one-bit direction select picks the conversion for each operand. Float-to-integer drops any fraction (rounding toward zero). Operands too large for a 32-bit integer, including infinities and NaNs, clamp to the most positive or most negative integer according to the sign bit. Integer-to-float gives the nearest single-precision value. When the integer has more significant bits than the 24-bit significand can hold, a tie rounds to the value with an even last bit.

The range test on the float path looks only at the raw biased exponent field. Any exponent up to 157 converts normally; any larger exponent saturates. A valid strobe enters with the operand. The block registers the result and raises its own valid output on the following clock edge. When no operand is presented, the output register keeps its value.

Top module: `fcvt_unit`

## Requirements
- R1: With dir_i=0 (float to integer) and a biased exponent field operand_i[30:23] in 127..157, result_o is the float's value truncated toward zero, as a two's-complement integer.
- R2: With dir_i=0, exponent field above 157 and operand_i[31]=1, result_o is 0x80000000. This covers negative infinity and NaNs with the sign bit set.
- R3: With dir_i=0, exponent field above 157 and operand_i[31]=0, result_o is 0x7FFFFFFF. This covers positive infinity and NaNs with the sign bit clear.
- R4: With dir_i=0 and exponent field below 127 (zeros, denormals and magnitudes under 1.0), result_o is 0x00000000 for either sign.
- R5: With dir_i=1 (integer to float), an integer of magnitude below 2^24 converts exactly to the IEEE-754 single-precision encoding: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0.
- R6: With dir_i=1 and a magnitude of 2^24 or more, the result rounds to nearest. A tie rounds to an even fraction.
- R7: With dir_i=1, operand 0 gives 0x00000000, and operand 0x80000000 gives exactly 0xCF000000 (-2^31).
- R8: valid_o is 1 exactly in the cycle after a cycle with valid_i=1, and the new result is on result_o in that same cycle. Reset drives valid_o and result_o to 0.
- R9: When valid_i is 0, result_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand strobe |
| dir_i | input | 1 | 0: float to integer, 1: integer to float |
| operand_i | input | 32 | Operand bit pattern |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 32 | Registered conversion result |

## Verification
Every result is due exactly one clock edge after its operand is strobed in. The bench drives each operand on a falling edge and compares result_o and valid_o on the next falling edge, so the single rising edge between them is the only one in the path. Back-to-back operands are checked in that same half-cycle-offset rhythm. Idle cycles that follow are checked for a low valid_o and an unchanged result_o.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = 23;

  typedef enum logic {
    CVT_F2W = 1'b0,
    CVT_W2F = 1'b1
  } cvt_dir_e;
endpackage

// File: rtl/fcvt_lzc.sv
`timescale 1ns/1ps
module fcvt_lzc #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o  = '0;
    zero_o = ~|d_i;
    // highest set bit wins since it is visited last
    for (int i = 0; i < int'(W); i++) begin
      if (d_i[i]) cnt_o = CW'(int'(W) - 1 - i);
    end
  end
endmodule

// File: rtl/fcvt_f2w.sv
`timescale 1ns/1ps
module fcvt_f2w #(
  parameter int unsigned DW = fcvt_pkg::DATA_W,
  parameter int unsigned EW = fcvt_pkg::EXP_W,
  parameter int unsigned MW = fcvt_pkg::MAN_W
) (
  input  logic [DW-1:0] f_i,
  output logic [DW-1:0] w_o
);
  localparam logic [EW-1:0] BIAS_E  = EW'((1 << (EW-1)) - 1);
  localparam logic [EW-1:0] SAT_E   = EW'((1 << (EW-1)) - 1 + DW - 2);
  localparam logic [EW-1:0] UNITY_E = EW'((1 << (EW-1)) - 1 + MW);

  logic          sign;
  logic [EW-1:0] exp_f;
  logic [DW-1:0] sig;
  logic [DW-1:0] mag;
  logic          in_range;

  assign sign     = f_i[DW-1];
  assign exp_f    = f_i[DW-2 -: EW];
  assign sig      = DW'({1'b1, f_i[MW-1:0]});
  assign in_range = (exp_f >= BIAS_E) && (exp_f <= SAT_E);

  always_comb begin
    mag = '0;
    if (exp_f >= UNITY_E) mag = sig << (exp_f - UNITY_E);
    else                  mag = sig >> (UNITY_E - exp_f);
  end

  always_comb begin
    if (exp_f > SAT_E)       w_o = sign ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else if (exp_f < BIAS_E) w_o = '0;
    else                     w_o = sign ? -mag : mag;
  end

  // R1: an in-range nonzero truncation never flips the sign
  always_comb begin
    if (in_range && (mag != '0)) begin
      a_r1_sign_kept: assert (w_o[DW-1] == sign);
    end
  end
endmodule

// File: rtl/fcvt_w2f.sv
`timescale 1ns/1ps
module fcvt_w2f #(
  parameter int unsigned DW = fcvt_pkg::DATA_W,
  parameter int unsigned EW = fcvt_pkg::EXP_W,
  parameter int unsigned MW = fcvt_pkg::MAN_W,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic [DW-1:0] w_i,
  output logic [DW-1:0] f_o
);
  localparam logic [EW-1:0] TOP_E = EW'((1 << (EW-1)) - 1 + DW - 1);

  logic          sign;
  logic [DW-1:0] mag;
  logic [DW-1:0] norm;
  logic [CW-1:0] lz;
  logic          zero;
  logic [EW-1:0] exp_b;
  logic [MW-1:0] kept;
  logic          lsb, guard, sticky, rnd_up;
  logic [DW-2:0] body;

  assign sign = w_i[DW-1];
  assign mag  = sign ? -w_i : w_i;

  fcvt_lzc #(.W(DW)) u_lzc (
    .d_i    (mag),
    .cnt_o  (lz),
    .zero_o (zero)
  );

  assign norm   = mag << lz;
  assign exp_b  = TOP_E - EW'(lz);
  assign kept   = norm[DW-2 -: MW];
  assign lsb    = norm[DW-1-MW];
  assign guard  = norm[DW-2-MW];
  assign sticky = |norm[DW-3-MW:0];
  assign rnd_up = guard & (sticky | lsb);
  // fraction carry ripples into the exponent
  assign body   = {exp_b, kept} + (DW-1)'(rnd_up);
  assign f_o    = zero ? '0 : {sign, body};

  // R6: rounding never reaches the all-ones exponent
  always_comb begin
    if (!zero) begin
      a_r6_no_exp_overflow: assert (!(&body[DW-2 -: EW]));
    end
  end
endmodule

// File: rtl/fcvt_unit.sv
`timescale 1ns/1ps
module fcvt_unit
  import fcvt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          dir_i,
  input  logic [DW-1:0] operand_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o
);
  localparam logic [EW-1:0] BIAS_E = EW'((1 << (EW-1)) - 1);
  localparam logic [EW-1:0] SAT_E  = EW'((1 << (EW-1)) - 1 + DW - 2);

  logic [DW-1:0] f2w_res, w2f_res, next_res;
  cvt_dir_e      dir;

  assign dir = cvt_dir_e'(dir_i);

  fcvt_f2w #(.DW(DW), .EW(EW), .MW(MW)) u_f2w (
    .f_i (operand_i),
    .w_o (f2w_res)
  );

  fcvt_w2f #(.DW(DW), .EW(EW), .MW(MW)) u_w2f (
    .w_i (operand_i),
    .f_o (w2f_res)
  );

  assign next_res = (dir == CVT_W2F) ? w2f_res : f2w_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_res;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r2_neg_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dir_i && operand_i[DW-1] && (operand_i[DW-2 -: EW] > SAT_E))
    |=> (result_o == {1'b1, {(DW-1){1'b0}}}));
  a_r3_pos_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dir_i && !operand_i[DW-1] && (operand_i[DW-2 -: EW] > SAT_E))
    |=> (result_o == {1'b0, {(DW-1){1'b1}}}));
  a_r4_small_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dir_i && (operand_i[DW-2 -: EW] < BIAS_E)) |=> (result_o == '0));
  a_r7_int_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dir_i && (operand_i == '0)) |=> (result_o == '0));
endmodule

// File: tb/fcvt_unit_tb.sv
`timescale 1ns/1ps
module fcvt_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  fcvt_unit u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .dir_i     (dir_i),
    .operand_i (operand_i),
    .valid_o   (valid_o),
    .result_o  (result_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_f2w(input logic [31:0] x);
    int  e = int'(x[30:23]);
    real v;
    int  t;
    if (e > 157) return x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (e < 127) return 32'h0;
    v = real'(8388608 + int'(x[22:0])) * (2.0 ** (e - 150));
    t = $rtoi(v);
    return x[31] ? 32'(-t) : 32'(t);
  endfunction

  function automatic logic [31:0] ref_w2f(input logic [31:0] x);
    longint sv = longint'($signed(x));
    bit     s = (sv < 0);
    real    mag = s ? -real'(sv) : real'(sv);
    int     e = 0;
    real    scaled, fr;
    longint q;
    if (sv == 0) return 32'h0;
    while ((2.0 ** (e + 1)) <= mag) e++;
    scaled = mag / (2.0 ** (e - 23));
    q = longint'($rtoi(scaled));
    fr = scaled - real'(q);
    if (fr > 0.5 || (fr == 0.5 && q[0])) q++;
    if (q == 64'd16777216) begin q = 64'd8388608; e++; end
    return {s, 8'(e + 127), q[22:0]};
  endfunction

  function automatic string tag_f2w(input logic [31:0] x);
    if (x[30:23] > 8'd157) return x[31] ? "R2" : "R3";
    if (x[30:23] < 8'd127) return "R4";
    return "R1";
  endfunction

  function automatic string tag_w2f(input logic [31:0] x);
    logic [31:0] m = x[31] ? -x : x;
    if (x == 32'h0 || x == 32'h8000_0000) return "R7";
    if (m >= 32'h0100_0000) return "R6";
    return "R5";
  endfunction

  // drive at a falling edge, result due at the next falling edge
  task automatic run(input bit d, input logic [31:0] op);
    logic [31:0] exp;
    string tag;
    dir_i = d; operand_i = op; valid_i = 1'b1;
    exp = d ? ref_w2f(op) : ref_f2w(op);
    tag = d ? tag_w2f(op) : tag_f2w(op);
    @(negedge clk_i);
    check(result_o == exp, tag, result_o, exp);
    check(valid_o == 1'b1, "R8", {31'b0, valid_o}, 32'h1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R8", {31'b0, valid_o}, 32'h0);
    check(result_o == 32'h0, "R8", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // float to integer corners
    run(1'b0, 32'h3F80_0000);  // R1 1.0
    run(1'b0, 32'hBFC0_0000);  // R1 -1.5 -> -1
    run(1'b0, 32'h4EFF_FFFF);  // R1 largest in-range exponent
    run(1'b0, 32'hCEFF_FFFF);  // R1
    run(1'b0, 32'h4F00_0000);  // R3 2^31
    run(1'b0, 32'hCF00_0000);  // R2 -2^31 saturates
    run(1'b0, 32'h7F80_0000);  // R3 +inf
    run(1'b0, 32'hFFC0_0000);  // R2 negative NaN
    run(1'b0, 32'h7FC0_0001);  // R3 NaN
    run(1'b0, 32'h0000_0001);  // R4 denormal
    run(1'b0, 32'h8000_0000);  // R4 -0.0
    run(1'b0, 32'h3F7F_FFFF);  // R4 just below 1.0
    run(1'b0, 32'hBF7F_FFFF);  // R4
    // integer to float corners
    run(1'b1, 32'h0000_0000);  // R7
    run(1'b1, 32'h8000_0000);  // R7
    run(1'b1, 32'h0000_0001);  // R5
    run(1'b1, 32'hFFFF_FFFF);  // R5 -1
    run(1'b1, 32'h00FF_FFFF);  // R5 24 bits exact
    run(1'b1, 32'h0100_0001);  // R6 tie to even, down
    run(1'b1, 32'h0100_0003);  // R6 tie to even, up
    run(1'b1, 32'h7FFF_FFFF);  // R6 carries into exponent
    run(1'b1, 32'hFEFF_FFFF);  // R6 negative
    run(1'b1, 32'h0100_0002);  // R6 exact

    for (int i = 0; i < 600; i++) begin
      logic [31:0] op = $urandom;
      bit d = i[0];
      if (!d && $urandom_range(0, 1) == 1) op[30:23] = 8'(120 + $urandom_range(0, 45));
      if (d) op = $signed(op) >>> $urandom_range(0, 31);
      run(d, op);
    end

    // R9 / R8: idle cycles keep the result, valid drops
    valid_i = 1'b0;
    held = result_o;
    operand_i = 32'h4000_0000;
    dir_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      check(valid_o == 1'b0, "R8", {31'b0, valid_o}, 32'h0);
      check(result_o == held, "R9", result_o, held);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule